// File: doc/BRIEF.md
# Page Table Entry Run Generator

This block fills a contiguous stretch of memory with 64-bit page-table entries that follow an arithmetic progression. A command gives a destination byte address, a starting value, a step, an OR-mask and a count. The count is one less than the number of entries wanted. One start strobe launches the run. The block then sends one entry per accepted beat over a 64-bit write port with a valid/ready handshake, and raises a single-cycle done pulse after the last entry has been accepted.

Entry i equals the mask ORed onto (start value + i × step), taken modulo 2^64. Each entry lands 8 bytes above the one before it. A packet decoder uses the done pulse to move on to the next command. The running value is built by adding the step once per accepted beat, so the block needs no multiplier.

Top module: `pte_run_gen`

## Requirements
- R1: After reset, `wr_valid_o`, `busy_o` and `done_o` are all low.
- R2: A start seen while idle is latched at that clock edge. From the next cycle `busy_o` and `wr_valid_o` are high, `wr_addr_o` is the destination and `wr_data_o` is mask | start value.
- R3: The i-th write (i counted from 0) carries `wr_data_o` = mask | ((start value + i × step) mod 2^64).
- R4: The i-th write carries `wr_addr_o` = (destination + 8 × i) mod 2^ADDR_W.
- R5: A count field of c produces exactly c+1 accepted writes. A count of 0 produces a single write.
- R6: While `wr_valid_o` is high and `wr_ready_i` is low, the next cycle keeps `wr_valid_o` high with `wr_addr_o` and `wr_data_o` unchanged.
- R7: In the cycle after the last write is accepted, `done_o` is high for exactly one cycle, and `busy_o` and `wr_valid_o` are low in that cycle.
- R8: A start asserted while busy is ignored. The run in progress keeps its latched operands, and no new run begins after it ends.
- R9: Command operands are sampled only at the accepted start. Changing them later has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a run when idle |
| dest_addr_i | input | ADDR_W | Byte address of the first entry |
| init_val_i | input | 64 | Value of entry 0 before masking |
| incr_i | input | 64 | Step added between entries |
| or_mask_i | input | 64 | Bits ORed into every entry |
| count_m1_i | input | CNT_W | Number of entries minus one |
| wr_valid_o | output | 1 | Write beat present |
| wr_ready_i | input | 1 | Memory accepts the beat |
| wr_addr_o | output | ADDR_W | Byte address of the beat |
| wr_data_o | output | 64 | Entry value of the beat |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse after the final accepted beat |

## Verification
A wrong accumulator or address register shows up on the very next beat after a handshake, as a mismatch in `wr_data_o` or `wr_addr_o` against the closed-form value for that index. A wrong remaining-count register shows up at the end of the run: either one beat too many appears in place of the done pulse, or done arrives while entries are still owed. Wrong handshake logic appears within one stalled cycle, as a beat that changes or disappears while ready is low.

// File: rtl/pte_run_gen.sv
module pte_run_gen #(
  parameter int ADDR_W = 48,
  parameter int CNT_W  = 16,
  localparam int DATA_W = 64,
  localparam int STEP_B = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] dest_addr_i,
  input  logic [DATA_W-1:0] init_val_i,
  input  logic [DATA_W-1:0] incr_i,
  input  logic [DATA_W-1:0] or_mask_i,
  input  logic [CNT_W-1:0]  count_m1_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              busy_o,
  output logic              done_o
);

  logic              busy_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] acc_q, incr_q, mask_q;
  logic [CNT_W-1:0]  left_q;
  logic              accept, last_beat;

  assign accept     = busy_q & wr_ready_i;
  assign last_beat  = accept & (left_q == '0);
  assign wr_valid_o = busy_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = mask_q | acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      acc_q  <= '0;
      incr_q <= '0;
      mask_q <= '0;
      left_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          addr_q <= dest_addr_i;
          acc_q  <= init_val_i;
          incr_q <= incr_i;
          mask_q <= or_mask_i;
          left_q <= count_m1_i;
        end
      end else if (last_beat) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (accept) begin
        addr_q <= addr_q + ADDR_W'(STEP_B);
        acc_q  <= acc_q + incr_q;
        left_q <= left_q - 1'b1;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !wr_valid_o && !done_o); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)); // R6

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && wr_ready_i && !last_beat |=> wr_valid_o && wr_addr_o == $past(wr_addr_o) + ADDR_W'(STEP_B)); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !wr_valid_o); // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !wr_ready_i |=> $stable(wr_addr_o) && $stable(wr_data_o)); // R8

endmodule

// File: tb/pte_run_gen_tb_top.sv
module pte_run_gen_tb_top;
  localparam int ADDR_W = 48;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] dest_addr_i = '0;
  logic [63:0]       init_val_i = '0, incr_i = '0, or_mask_i = '0;
  logic [CNT_W-1:0]  count_m1_i = '0;
  logic              wr_valid_o, wr_ready_i = 1'b0, busy_o, done_o;
  logic [ADDR_W-1:0] wr_addr_o;
  logic [63:0]       wr_data_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pte_run_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dest_addr_i(dest_addr_i),
    .init_val_i(init_val_i), .incr_i(incr_i), .or_mask_i(or_mask_i),
    .count_m1_i(count_m1_i), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .busy_o(busy_o), .done_o(done_o));

  function automatic logic [63:0] exp_entry(logic [63:0] iv, logic [63:0] inc,
                                            logic [63:0] m, int i);
    logic [63:0] prod = inc * 64'(i);
    return m | (iv + prod);
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr(logic [ADDR_W-1:0] d, int i);
    return d + ADDR_W'(8 * i);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // rmode: 0 always ready, 1 random ready, 2 ready mostly low
  task automatic run_job(input logic [ADDR_W-1:0] d, input logic [63:0] iv,
                         input logic [63:0] inc, input logic [63:0] m,
                         input logic [CNT_W-1:0] c, input int rmode, input bit poke);
    int idx = 0;
    bit prev_stall = 0;
    logic [ADDR_W-1:0] prev_a = '0;
    logic [63:0] prev_d = '0;
    @(negedge clk);
    check("R8 idle before start", {63'd0, busy_o}, 64'd0);
    dest_addr_i = d; init_val_i = iv; incr_i = inc; or_mask_i = m; count_m1_i = c;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    dest_addr_i = ~d; init_val_i = ~iv; incr_i = inc + 64'd3; or_mask_i = ~m; count_m1_i = ~c; // R9
    check("R2 busy after start", {62'd0, busy_o, wr_valid_o}, 64'd3);
    while (idx <= int'(c)) begin
      bit r;
      if (!wr_valid_o) begin
        check("R5 beat missing before count reached", {63'd0, wr_valid_o}, 64'd1);
        break;
      end
      check($sformatf("R3 data idx %0d", idx), wr_data_o, exp_entry(iv, inc, m, idx));
      check($sformatf("R4 addr idx %0d", idx), 64'(wr_addr_o), 64'(exp_addr(d, idx)));
      if (prev_stall) begin
        check("R6 addr held", 64'(wr_addr_o), 64'(prev_a));
        check("R6 data held", wr_data_o, prev_d);
      end
      case (rmode)
        0: r = 1'b1;
        1: r = 1'($urandom_range(0, 1));
        default: r = ($urandom_range(0, 3) == 0);
      endcase
      wr_ready_i = r;
      if (poke && idx == 1) begin
        start_i = 1'b1; // R8
        dest_addr_i = d + 48'h1000; init_val_i = 64'hDEAD; count_m1_i = 16'd40;
      end
      prev_stall = !r; prev_a = wr_addr_o; prev_d = wr_data_o;
      if (r) idx++;
      @(negedge clk);
      start_i = 1'b0;
    end
    wr_ready_i = 1'b0;
    check("R7 done after last beat", {61'd0, done_o, busy_o, wr_valid_o}, 64'd4);
    check("R5 no extra beat", {63'd0, wr_valid_o}, 64'd0);
    @(negedge clk);
    check("R7 done one cycle", {63'd0, done_o}, 64'd0);
    check("R8 no run after ignored start", {62'd0, busy_o, wr_valid_o}, 64'd0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'd0, wr_valid_o}, 64'd0);
    check("R1 reset busy", {63'd0, busy_o}, 64'd0);
    check("R1 reset done", {63'd0, done_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_job(48'h0000_0010_0000, 64'h0000_0000_0000_1000, 64'h1000, 64'h1, 16'd0, 0, 0); // R5 single
    run_job(48'hFFFF_FFFF_FFF0, 64'h11, 64'h2, 64'h8000_0000_0000_0000, 16'd4, 0, 0);    // R4 wrap
    run_job(48'h2000, 64'hFFFF_FFFF_FFFF_FFF0, 64'h8, 64'h0, 16'd5, 1, 0);               // R3 wrap
    run_job(48'h3000, 64'h100, 64'h1000, 64'h63, 16'd6, 2, 1);                           // R6 R8
    run_job(48'h4000, 64'h7, 64'h0, 64'hF0, 16'd2, 1, 1);
    for (int k = 0; k < 24; k++) begin
      run_job({$urandom, $urandom} & 48'hFFFF_FFFF_FFF8,
              {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
              CNT_W'($urandom_range(0, 20)), k % 3, (k % 4) == 1);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc = 0;
    while (cyc < 100000 && !finished) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule